// File: doc/BRIEF.md
# DDR2 Mode Register Command Decoder

This block sits on the memory side of a DDR2 command bus. On every rising clock edge it samples the chip-select, row strobe, column strobe and write-enable lines, the two bank-select bits, the address bus and a status input that reports whether every bank is idle. When all four control lines are low, the edge carries a mode-register write. The bank-select value chooses which of four registers takes the address word: the main mode register or one of the three extended registers.

Each write is checked before it is applied. The checker looks at bank state, clock-enable history, the minimum command spacing after a write, and the setting values carried in the main register's word. A write that breaks any rule leaves its register unchanged and raises a one-cycle error pulse. The block also follows the programming order. Read and write access is allowed only once all four registers have been written. After either of the upper two extended registers is rewritten, access stays blocked until both the main register and extended register 1 have been written again.

The main register is presented as decoded fields. The three extended registers are presented as raw words.

Top module: `ddr2_mrdec`

## Requirements
- R1: A mode-register write occurs only at a rising edge where cs_n, ras_n, cas_n and we_n are all 0. The ba value (0 main, 1, 2 or 3 extended) selects the target. Any other pin pattern, including a deselected bus (cs_n high), changes no register.
- R2: After an accepted write to register 0, the outputs from the next cycle on are: burst_len = A[2:0], burst_seq = A[3], cas_lat = A[6:4], dll_rst = A[8], wr_rec = A[11:9], pd_slow = A[12]. For registers 1 to 3, extN_word equals the full address word.
- R3: A write is rejected and err_state pulses in the following cycle in each of these cases: banks_idle is low at the edge, cke is low at the edge, or cke was low at the previous edge.
- R4: A command is any edge with cs_n low and {ras_n,cas_n,we_n} not 3'b111. A command arriving fewer than TMRD edges after an accepted write makes err_timing pulse in the following cycle. If that command is a write, it is not applied.
- R5: A write to register 0 is rejected, with an err_setting pulse in the following cycle, in each of these cases: A[7] is 1, A[13] is 1, or A[2:0] is neither 3'b010 (burst of 4) nor 3'b011 (burst of 8).
- R6: Reset clears reg_valid. Bit N of reg_valid sets on the first accepted write to register N and never clears afterwards.
- R7: access_en is high only when all four reg_valid bits are set and no reprogramming is pending.
- R8: An accepted write to register 2 or 3 drops access_en in the next cycle. access_en stays low until both register 0 and register 1 have been accepted afterwards, in either order.
- R9: Error outputs last a single cycle for a single offending edge and are low when no rule is broken.
- R10: During reset, all register outputs, valid flags, access_en and error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select, chooses the target register |
| addr | input | AW | Address bus carrying the register word |
| banks_idle | input | 1 | High when every bank is precharged |
| burst_len | output | 3 | Burst length code |
| burst_seq | output | 1 | Burst ordering select |
| cas_lat | output | 3 | CAS latency code |
| dll_rst | output | 1 | DLL reset request bit |
| wr_rec | output | 3 | Write recovery code |
| pd_slow | output | 1 | Low-power power-down select |
| ext1_word | output | AW | Extended register 1 contents |
| ext2_word | output | AW | Extended register 2 contents |
| ext3_word | output | AW | Extended register 3 contents |
| reg_valid | output | 4 | Per-register written-once flags |
| access_en | output | 1 | Read/write access permitted |
| err_state | output | 1 | Pulse: write while banks busy or cke not stable |
| err_timing | output | 1 | Pulse: command inside the post-write gap |
| err_setting | output | 1 | Pulse: illegal main register setting |

## Verification
The hardest case to reach is a write that fails only on clock-enable history. At that edge cke is high and banks are idle, but cke was low at the edge before. The stimulus holds cke low for exactly one cycle, raises it, and issues the write at the very next edge.

A similar case is a write rejected only for spacing. The stimulus places it at the edge directly after an accepted write and then confirms that the target word still holds its earlier value. Reprogramming order is covered by rewriting an upper extended register after access is enabled, and watching access_en across the two repair writes.

// File: rtl/mrdec_pkg.sv
package mrdec_pkg;

  localparam logic [1:0] SEL_MAIN = 2'd0;
  localparam logic [1:0] SEL_EXT1 = 2'd1;
  localparam logic [1:0] SEL_EXT2 = 2'd2;
  localparam logic [1:0] SEL_EXT3 = 2'd3;

  localparam logic [2:0] BL_FOUR  = 3'b010;
  localparam logic [2:0] BL_EIGHT = 3'b011;

  typedef struct packed {
    logic       pd_slow;
    logic [2:0] wr_rec;
    logic       dll_rst;
    logic [2:0] cas_lat;
    logic       burst_seq;
    logic [2:0] burst_len;
  } main_fields_t;

  function automatic main_fields_t split_main(input logic [13:0] w);
    main_fields_t f;
    f.burst_len = w[2:0];
    f.burst_seq = w[3];
    f.cas_lat   = w[6:4];
    f.dll_rst   = w[8];
    f.wr_rec    = w[11:9];
    f.pd_slow   = w[12];
    return f;
  endfunction

  function automatic logic burst_code_ok(input logic [2:0] c);
    return (c == BL_FOUR) || (c == BL_EIGHT);
  endfunction

endpackage

// File: rtl/mrdec_guard.sv
module mrdec_guard
  import mrdec_pkg::*;
#(
  parameter int AW   = 14,
  parameter int TMRD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [1:0]    ba,
  input  logic [AW-1:0] addr,
  input  logic          banks_idle,
  output logic          wr_go,
  output logic [1:0]    wr_sel,
  output logic [AW-1:0] wr_data,
  output logic          err_state,
  output logic          err_timing,
  output logic          err_setting
);

  localparam int CW = (TMRD > 1) ? $clog2(TMRD) : 1;
  localparam logic [CW-1:0] GAP_LOAD = CW'(TMRD - 1);

  logic          cke_prev_q, cke_prev_d;
  logic [CW-1:0] gap_q, gap_d;
  logic          es_q, et_q, eg_q;
  logic          es_d, et_d, eg_d;

  logic cmd_any, is_mrw, in_gap, bad_state, bad_time, bad_set;

  always_comb begin
    cmd_any   = !cs_n && !(ras_n && cas_n && we_n);
    is_mrw    = !cs_n && !ras_n && !cas_n && !we_n;
    in_gap    = (gap_q != '0);
    bad_state = is_mrw && !(banks_idle && cke && cke_prev_q);
    bad_time  = cmd_any && in_gap;
    bad_set   = is_mrw && (ba == SEL_MAIN) &&
                (addr[7] || (addr[AW-1:13] != '0) || !burst_code_ok(addr[2:0]));
    wr_go     = is_mrw && !bad_state && !bad_time && !bad_set;
    wr_sel    = ba;
    wr_data   = addr;
  end

  always_comb begin
    cke_prev_d = cke;
    if (wr_go)       gap_d = GAP_LOAD;
    else if (in_gap) gap_d = gap_q - 1'b1;
    else             gap_d = gap_q;
    es_d = bad_state;
    et_d = bad_time;
    eg_d = bad_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev_q <= 1'b0;
      gap_q      <= '0;
      es_q       <= 1'b0;
      et_q       <= 1'b0;
      eg_q       <= 1'b0;
    end else begin
      cke_prev_q <= cke_prev_d;
      gap_q      <= gap_d;
      es_q       <= es_d;
      et_q       <= et_d;
      eg_q       <= eg_d;
    end
  end

  assign err_state   = es_q;
  assign err_timing  = et_q;
  assign err_setting = eg_q;

  // R3: a write while banks are busy must produce a state error next cycle
  a_r3_busy_banks_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrw && !banks_idle) |=> err_state);

  // R4: any command inside the gap is flagged in the following cycle
  a_r4_gap_command_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_any && in_gap) |=> err_timing);

  // R5: a setting error never coincides with an applied write
  a_r5_setting_not_applied: assert property (@(posedge clk) disable iff (!rst_n)
    err_setting |-> $past(!wr_go));

  // R4: an accepted write is never inside the gap
  a_r4_go_outside_gap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> !in_gap);

endmodule

// File: rtl/mrdec_regs.sv
module mrdec_regs #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  parameter int SW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_go,
  input  logic [SW-1:0]            wr_sel,
  input  logic [AW-1:0]            wr_data,
  output logic [NREG-1:0][AW-1:0]  word_o,
  output logic [NREG-1:0]          valid_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          hit;
    logic [AW-1:0] word_q, word_d;
    logic          val_q, val_d;

    always_comb begin
      hit    = wr_go && (wr_sel == SW'(i));
      word_d = hit ? wr_data : word_q;
      val_d  = val_q | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        val_q  <= 1'b0;
      end else begin
        word_q <= word_d;
        val_q  <= val_d;
      end
    end

    assign word_o[i]  = word_q;
    assign valid_o[i] = val_q;

    // R6: a valid flag never falls outside reset
    a_r6_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(val_q));
  end

endmodule

// File: rtl/mrdec_order.sv
module mrdec_order
  import mrdec_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_go,
  input  logic [1:0]      wr_sel,
  input  logic [NREG-1:0] valid,
  output logic            access_en
);

  logic need_main_q, need_main_d;
  logic need_ext1_q, need_ext1_d;

  always_comb begin
    need_main_d = need_main_q;
    need_ext1_d = need_ext1_q;
    if (wr_go) begin
      unique case (wr_sel)
        SEL_MAIN: need_main_d = 1'b0;
        SEL_EXT1: need_ext1_d = 1'b0;
        default: begin
          need_main_d = 1'b1;
          need_ext1_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_main_q <= 1'b0;
      need_ext1_q <= 1'b0;
    end else begin
      need_main_q <= need_main_d;
      need_ext1_q <= need_ext1_d;
    end
  end

  assign access_en = (&valid) && !need_main_q && !need_ext1_q;

  // R8: rewriting an upper extended register blocks access next cycle
  a_r8_upper_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_sel[1]) |=> !access_en);

  // R7: access requires every register written
  a_r7_access_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    access_en |-> (&valid));

endmodule

// File: rtl/ddr2_mrdec.sv
module ddr2_mrdec
  import mrdec_pkg::*;
#(
  parameter int AW   = 14,
  parameter int BAW  = 2,
  parameter int TMRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BAW-1:0]   ba,
  input  logic [AW-1:0]    addr,
  input  logic             banks_idle,
  output logic [2:0]       burst_len,
  output logic             burst_seq,
  output logic [2:0]       cas_lat,
  output logic             dll_rst,
  output logic [2:0]       wr_rec,
  output logic             pd_slow,
  output logic [AW-1:0]    ext1_word,
  output logic [AW-1:0]    ext2_word,
  output logic [AW-1:0]    ext3_word,
  output logic [3:0]       reg_valid,
  output logic             access_en,
  output logic             err_state,
  output logic             err_timing,
  output logic             err_setting
);

  localparam int NREG = 1 << BAW;

  logic sync1_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      sync1_q    <= 1'b1;
      rst_sync_n <= sync1_q;
    end
  end

  logic                    wr_go;
  logic [1:0]              wr_sel;
  logic [AW-1:0]           wr_data;
  logic [NREG-1:0][AW-1:0] words;
  logic [NREG-1:0]         valid;
  main_fields_t            mf;
  logic                    unused_main_bits;

  mrdec_guard #(.AW(AW), .TMRD(TMRD)) u_guard (
    .clk(clk), .rst_n(rst_sync_n), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .wr_go(wr_go), .wr_sel(wr_sel), .wr_data(wr_data),
    .err_state(err_state), .err_timing(err_timing), .err_setting(err_setting)
  );

  mrdec_regs #(.AW(AW), .NREG(NREG), .SW(BAW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_go(wr_go), .wr_sel(wr_sel),
    .wr_data(wr_data), .word_o(words), .valid_o(valid)
  );

  mrdec_order #(.NREG(NREG)) u_order (
    .clk(clk), .rst_n(rst_sync_n), .wr_go(wr_go), .wr_sel(wr_sel),
    .valid(valid), .access_en(access_en)
  );

  always_comb begin
    mf = split_main(words[0][13:0]);
  end

  assign unused_main_bits = ^{words[0][7], words[0][AW-1:13]};

  assign burst_len = mf.burst_len;
  assign burst_seq = mf.burst_seq;
  assign cas_lat   = mf.cas_lat;
  assign dll_rst   = mf.dll_rst;
  assign wr_rec    = mf.wr_rec;
  assign pd_slow   = mf.pd_slow;
  assign ext1_word = words[1];
  assign ext2_word = words[2];
  assign ext3_word = words[3];
  assign reg_valid = valid;

  // R5: a stored main word never carries an illegal burst code
  a_r5_stored_burst_legal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid[0] |-> burst_code_ok(burst_len));

endmodule

// File: tb/sim_ddr2_mrdec.sv
`timescale 1ns/1ps
module sim_ddr2_mrdec;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, banks_idle;
  logic [1:0]  ba;
  logic [13:0] addr;
  logic [2:0]  burst_len, cas_lat, wr_rec;
  logic        burst_seq, dll_rst, pd_slow;
  logic [13:0] ext1_word, ext2_word, ext3_word;
  logic [3:0]  reg_valid;
  logic        access_en, err_state, err_timing, err_setting;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddr2_mrdec u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .burst_len(burst_len), .burst_seq(burst_seq), .cas_lat(cas_lat),
    .dll_rst(dll_rst), .wr_rec(wr_rec), .pd_slow(pd_slow),
    .ext1_word(ext1_word), .ext2_word(ext2_word), .ext3_word(ext3_word),
    .reg_valid(reg_valid), .access_en(access_en), .err_state(err_state),
    .err_timing(err_timing), .err_setting(err_setting)
  );

  function automatic logic [13:0] mk(input logic [2:0] bl, input logic bt,
      input logic [2:0] cl, input logic dl, input logic [2:0] wr, input logic pd);
    return {1'b0, pd, wr, dl, 1'b0, cl, bt, bl};
  endfunction

  function automatic logic [11:0] fields_of(input logic [13:0] w);
    return {w[12], w[11:9], w[8], w[6:4], w[3], w[2:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] c, input logic [1:0] b, input logic [13:0] a);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    addr = a;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
  endtask

  task automatic wr(input logic [1:0] b, input logic [13:0] a);
    cmd(4'b0000, b, a);
    @(negedge clk);
  endtask

  function automatic logic [11:0] cur_fields();
    return {pd_slow, wr_rec, dll_rst, cas_lat, burst_seq, burst_len};
  endfunction

  logic [13:0] wa, wb;

  task automatic t_reset();
    check("R10 valid", 32'(reg_valid), 0);
    check("R10 access", 32'(access_en), 0);
    check("R10 errors", 32'({err_state, err_timing, err_setting}), 0);
    check("R10 main", 32'(cur_fields()), 0);
    check("R10 ext", 32'({ext1_word, ext2_word, ext3_word}), 0);
  endtask

  task automatic t_first_program();
    wr(2'd2, 14'h0015);
    check("R6 ext2 valid", 32'(reg_valid), 32'h4);
    check("R2 ext2 word", 32'(ext2_word), 32'h0015);
    wr(2'd3, 14'h0002);
    wr(2'd1, 14'h0444);
    check("R7 access low missing main", 32'(access_en), 0);
    check("R6 valid three", 32'(reg_valid), 32'hE);
    wr(2'd0, wa);
    check("R7 access high", 32'(access_en), 1);
    check("R2 main fields", 32'(cur_fields()), 32'(fields_of(wa)));
    check("R2 ext1 word", 32'(ext1_word), 32'h0444);
  endtask

  task automatic t_ignore();
    cmd(4'b0001, 2'd0, wb);
    @(negedge clk);
    check("R1 refresh no write", 32'(cur_fields()), 32'(fields_of(wa)));
    cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; ba = 2'd1; addr = 14'h1234;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    check("R1 deselect no write", 32'(ext1_word), 32'h0444);
  endtask

  task automatic t_state();
    banks_idle = 1'b0;
    cmd(4'b0000, 2'd0, wb);
    check("R3 busy flag", 32'(err_state), 1);
    check("R3 busy no write", 32'(cur_fields()), 32'(fields_of(wa)));
    banks_idle = 1'b1;
    @(negedge clk);
    check("R9 state pulse ends", 32'(err_state), 0);
    cke = 1'b0;
    @(negedge clk);
    cke = 1'b1;
    cmd(4'b0000, 2'd1, 14'h0777);
    check("R3 cke history flag", 32'(err_state), 1);
    check("R3 cke history no write", 32'(ext1_word), 32'h0444);
    @(negedge clk);
  endtask

  task automatic t_timing();
    cmd(4'b0000, 2'd1, 14'h0101);
    cmd(4'b0101, 2'd0, 14'h0000);
    check("R4 read in gap", 32'(err_timing), 1);
    @(negedge clk);
    check("R9 timing pulse ends", 32'(err_timing), 0);
    cmd(4'b0000, 2'd1, 14'h0202);
    cmd(4'b0000, 2'd1, 14'h0303);
    check("R4 write in gap flagged", 32'(err_timing), 1);
    check("R4 write in gap ignored", 32'(ext1_word), 32'h0202);
    @(negedge clk);
    cmd(4'b0101, 2'd0, 14'h0000);
    check("R4 read after gap ok", 32'(err_timing), 0);
    @(negedge clk);
  endtask

  task automatic t_setting();
    wr(2'd0, wb | 14'h0080);
    check("R5 A7 ignored", 32'(cur_fields()), 32'(fields_of(wa)));
    cmd(4'b0000, 2'd0, wb | 14'h2000);
    check("R5 A13 flagged", 32'(err_setting), 1);
    @(negedge clk);
    check("R9 setting pulse ends", 32'(err_setting), 0);
    cmd(4'b0000, 2'd0, {wb[13:3], 3'b001});
    check("R5 burst code flagged", 32'(err_setting), 1);
    check("R5 burst code ignored", 32'(cur_fields()), 32'(fields_of(wa)));
    @(negedge clk);
    wr(2'd0, wb);
    check("R2 second fields", 32'(cur_fields()), 32'(fields_of(wb)));
    check("R9 legal no errors", 32'({err_state, err_timing, err_setting}), 0);
  endtask

  task automatic t_order();
    wr(2'd3, 14'h0009);
    check("R8 upper write blocks", 32'(access_en), 0);
    wr(2'd0, wa);
    check("R8 main alone not enough", 32'(access_en), 0);
    wr(2'd1, 14'h0040);
    check("R8 restored", 32'(access_en), 1);
    wr(2'd2, 14'h0003);
    wr(2'd1, 14'h0041);
    check("R8 ext1 alone not enough", 32'(access_en), 0);
    wr(2'd0, wb);
    check("R8 restored other order", 32'(access_en), 1);
    check("R6 all valid", 32'(reg_valid), 32'hF);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wa = mk(3'b011, 1'b1, 3'b101, 1'b1, 3'b110, 1'b1);
    wb = mk(3'b010, 1'b0, 3'b011, 1'b0, 3'b001, 1'b0);
    rst_n = 1'b0; cke = 1'b0; banks_idle = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111; ba = 2'd0; addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cke = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_program();
    t_ignore();
    t_state();
    t_timing();
    t_setting();
    t_order();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule